// File: doc/BRIEF.md
# Four-Lane 8b/10b Serial Pixel Transmitter

This block turns a handshaked stream of 12-bit pixel samples into four DC-balanced serial lanes whose clock can be recovered from the data. Pixels are paired, and each pair is packed into three bytes. The bytes are dealt across the lanes in stream order, four per symbol slot. Each lane encodes its byte with 8b/10b and keeps its own running disparity. A 10:1 shift register then sends the 10-bit symbol one bit per bit-clock cycle. Because every lane starts and ends its symbols on the same bit-clock cycle, a receiver can merge the lanes without any skew training.

A pixel that opens a line or a frame carries a marker flag. The block first sends every byte queued ahead of that pixel. It then sends one control symbol on all four lanes in a single slot, and stalls new input until that slot has gone out. When there is nothing to send, all lanes carry the comma symbol so that the receiver keeps symbol alignment. The bit clock is modelled as the single block clock.

Top module: `emb_lane_tx`

## Requirements
- R1: After reset, every lane starts from negative running disparity. The first symbol on every lane is K28.5 in its negative form. Written as abcdei fghj, that symbol is 001111 1010.
- R2: Every symbol lasts exactly 10 clock cycles. Bit a goes out first and bit j last. The symbol boundaries fall on the same cycle on all lanes.
- R3: Data bytes follow the standard 8b/10b code. The low five bits (EDCBA) select the 6-bit sub-block and the high three bits (HGF) select the 4-bit sub-block. The D.x.7 alternate form is used where the standard code requires it. Each lane tracks its disparity on its own, so every symbol has 4, 5 or 6 ones, and a symbol is never unbalanced in the same direction as the running disparity before it.
- R4: Two accepted pixels P (first) and Q (second) form the 24-bit word {Q, P}. This word is sent as bytes in the order [7:0], [15:8], [23:16].
- R5: A data slot carries four consecutive stream bytes, in order, on lanes 0 to 3. Bytes wait in the buffer until four are present, except when a flush is needed before a marker (R8).
- R6: A slot with nothing to send carries K28.5 on every lane.
- R7: A pixel flagged as line start causes K28.0 to be sent on all lanes in one slot. A pixel flagged as frame start causes K28.2 to be sent instead, and the frame-start flag takes precedence if both flags are set. The marker slot comes after every byte from earlier pixels and before any byte that includes the flagged pixel.
- R8: If fewer than four bytes remain when a marker is due, they go out in one slot on lanes 0 upward, with K28.5 on the unused lanes. The marker goes in the next slot, so the next line's bytes start on lane 0.
- R9: in_ready drops in the cycle after a flagged pixel is accepted and stays low until its marker slot has been loaded. in_ready is also low while the buffer has room for fewer than three more bytes. No accepted byte is lost.
- R10: A flagged pixel always starts a new pair. If a line ends on an unpaired pixel, that pixel is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel sample offered |
| in_ready | output | 1 | Block accepts the offered pixel this cycle |
| in_pix | input | 12 | Pixel sample |
| in_sol | input | 1 | Offered pixel is the first of a line |
| in_sof | input | 1 | Offered pixel is the first of a frame |
| lane_o | output | 4 | Serial bit of each lane |

## Verification
The bench builds the block with four lanes and an eight-byte buffer. With these values, input is throttled often: a pixel arrives at most every cycle, but the four lanes drain only 0.4 bytes per cycle. Short random lines end in every possible buffer fill, so flush slots of one, two and three bytes all occur. The bench decodes every lane independently, using its own disparity bookkeeping. This shows alternate-form bytes, D.x.7 and D.x.3 polarity, and marker placement against a pixel-level model.

// File: rtl/elc_pkg.sv
package elc_pkg;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int PIX_W  = 12;
    localparam int GRP    = 3;   // bytes per pixel pair

    localparam logic [BYTE_W-1:0] K_IDLE  = 8'hBC;  // K28.5
    localparam logic [BYTE_W-1:0] K_LINE  = 8'h1C;  // K28.0
    localparam logic [BYTE_W-1:0] K_FRAME = 8'h5C;  // K28.2

    typedef enum logic [1:0] {SK_IDLE, SK_DATA, SK_LINE, SK_FRAME} sym_kind_e;

    typedef struct packed {
        sym_kind_e         kind;
        logic [BYTE_W-1:0] val;
    } lane_sym_t;

    typedef struct packed {
        logic [SYM_W-1:0] code;   // bit 0 is transmitted first (bit a)
        logic             rd_pos;
    } enc_res_t;

    // 6-bit sub-block, negative-disparity form, written abcdei with a as MSB
    function automatic logic [5:0] tab6(input logic [4:0] x);
        case (x)
            5'd0:  tab6 = 6'b100111;  5'd1:  tab6 = 6'b011101;
            5'd2:  tab6 = 6'b101101;  5'd3:  tab6 = 6'b110001;
            5'd4:  tab6 = 6'b110101;  5'd5:  tab6 = 6'b101001;
            5'd6:  tab6 = 6'b011001;  5'd7:  tab6 = 6'b111000;
            5'd8:  tab6 = 6'b111001;  5'd9:  tab6 = 6'b100101;
            5'd10: tab6 = 6'b010101;  5'd11: tab6 = 6'b110100;
            5'd12: tab6 = 6'b001101;  5'd13: tab6 = 6'b101100;
            5'd14: tab6 = 6'b011100;  5'd15: tab6 = 6'b010111;
            5'd16: tab6 = 6'b011011;  5'd17: tab6 = 6'b100011;
            5'd18: tab6 = 6'b010011;  5'd19: tab6 = 6'b110010;
            5'd20: tab6 = 6'b001011;  5'd21: tab6 = 6'b101010;
            5'd22: tab6 = 6'b011010;  5'd23: tab6 = 6'b111010;
            5'd24: tab6 = 6'b110011;  5'd25: tab6 = 6'b100110;
            5'd26: tab6 = 6'b010110;  5'd27: tab6 = 6'b110110;
            5'd28: tab6 = 6'b001110;  5'd29: tab6 = 6'b101110;
            5'd30: tab6 = 6'b011110;  default: tab6 = 6'b101011;
        endcase
    endfunction

    // 4-bit sub-block, negative-disparity form, written fghj with f as MSB
    function automatic logic [3:0] tab4(input logic [2:0] y);
        case (y)
            3'd0: tab4 = 4'b1011;  3'd1: tab4 = 4'b1001;
            3'd2: tab4 = 4'b0101;  3'd3: tab4 = 4'b1100;
            3'd4: tab4 = 4'b1101;  3'd5: tab4 = 4'b1010;
            3'd6: tab4 = 4'b0110;  default: tab4 = 4'b1110;
        endcase
    endfunction

    // K28.y is built on the negative path and inverted for positive disparity
    function automatic enc_res_t encode(input logic [7:0] d, input logic is_k,
                                        input logic rd_pos);
        logic [4:0] x;
        logic [2:0] y;
        logic       r0, rmid, alt;
        logic [5:0] a6, c6;
        logic [3:0] a4, c4;
        logic [9:0] full;
        int         ones;
        x    = d[4:0];
        y    = d[7:5];
        r0   = is_k ? 1'b0 : rd_pos;
        a6   = is_k ? 6'b001111 : tab6(x);
        c6   = (r0 && (($countones(a6) != 3) || (x == 5'd7))) ? ~a6 : a6;
        ones = $countones(c6);
        rmid = (ones > 3) ? 1'b1 : ((ones < 3) ? 1'b0 : r0);
        alt  = !is_k && (y == 3'd7) &&
               (rmid ? ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))
                     : ((x == 5'd17) || (x == 5'd18) || (x == 5'd20)));
        a4   = alt ? 4'b0111 : tab4(y);
        c4   = (rmid && (($countones(a4) != 2) || (y == 3'd3))) ? ~a4 : a4;
        full = {c6, c4};
        if (is_k && rd_pos) full = ~full;
        for (int i = 0; i < SYM_W; i++) encode.code[i] = full[SYM_W-1-i];
        ones = $countones(full);
        encode.rd_pos = (ones > 5) ? 1'b1 : ((ones < 5) ? 1'b0 : rd_pos);
    endfunction

endpackage

// File: rtl/elc_pack.sv
module elc_pack
    import elc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int BUF_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PIX_W-1:0]        in_pix,
    input  logic                    in_sol,
    input  logic                    in_sof,
    input  logic                    take,
    output logic                    in_ready,
    output lane_sym_t [LANES-1:0]   plan
);
    localparam int CW = $clog2(BUF_BYTES + 1);
    localparam int IW = $clog2(BUF_BYTES);

    logic [BYTE_W-1:0] buf_q [BUF_BYTES];
    logic [BYTE_W-1:0] buf_d [BUF_BYTES];
    logic [CW-1:0]     cnt_q, cnt_d;
    sym_kind_e         pend_q, pend_d;   // SK_IDLE means no marker pending
    logic              half_q, half_d;
    logic [PIX_W-1:0]  held_q, held_d;
    int                npop;
    logic              mk_slot;

    // slot plan: full data slot, flush slot, marker slot or idle
    always_comb begin
        npop    = 0;
        mk_slot = 1'b0;
        for (int l = 0; l < LANES; l++) plan[l] = '{kind: SK_IDLE, val: K_IDLE};
        if (int'(cnt_q) >= LANES) begin
            for (int l = 0; l < LANES; l++) plan[l] = '{kind: SK_DATA, val: buf_q[IW'(l)]};
            npop = LANES;
        end else if (pend_q != SK_IDLE) begin
            if (cnt_q != '0) begin
                for (int l = 0; l < LANES; l++)
                    if (l < int'(cnt_q)) plan[l] = '{kind: SK_DATA, val: buf_q[IW'(l)]};
                npop = int'(cnt_q);
            end else begin
                for (int l = 0; l < LANES; l++)
                    plan[l] = '{kind: pend_q, val: (pend_q == SK_LINE) ? K_LINE : K_FRAME};
                mk_slot = 1'b1;
            end
        end
    end

    assign in_ready = (pend_q == SK_IDLE) && (int'(cnt_q) <= BUF_BYTES - GRP);

    logic                    acc, is_mk, push;
    logic [2*PIX_W-1:0]      pair;
    int                      pop_n, base, off;

    always_comb begin
        acc    = in_valid && in_ready;
        is_mk  = in_sol || in_sof;
        push   = acc && !is_mk && half_q;
        pair   = {in_pix, held_q};
        pop_n  = take ? npop : 0;
        base   = int'(cnt_q) - pop_n;
        for (int i = 0; i < BUF_BYTES; i++) begin
            buf_d[i] = (i + pop_n < BUF_BYTES) ? buf_q[IW'(i + pop_n)] : '0;
            off = i - base;
            if (push && off >= 0 && off < GRP) begin
                case (off)
                    0:       buf_d[i] = pair[7:0];
                    1:       buf_d[i] = pair[15:8];
                    default: buf_d[i] = pair[23:16];
                endcase
            end
        end
        cnt_d  = CW'(base + (push ? GRP : 0));
        pend_d = (take && mk_slot) ? SK_IDLE : pend_q;
        half_d = half_q;
        held_d = held_q;
        if (acc) begin
            if (is_mk) begin
                pend_d = in_sof ? SK_FRAME : SK_LINE;
                held_d = in_pix;
                half_d = 1'b1;
            end else if (half_q) begin
                half_d = 1'b0;
            end else begin
                held_d = in_pix;
                half_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        buf_q <= buf_d;
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= SK_IDLE;
            half_q <= 1'b0;
            held_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            half_q <= half_d;
            held_q <= held_d;
        end
    end

endmodule

// File: rtl/elc_lane.sv
module elc_lane
    import elc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  lane_sym_t sym,
    output logic      bit_o
);
    logic [SYM_W-1:0] sr_q;
    logic             rd_q;
    enc_res_t         enc;

    always_comb enc = encode(sym.val, sym.kind != SK_DATA, rd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            rd_q <= 1'b0;
        end else if (load) begin
            sr_q <= enc.code;
            rd_q <= enc.rd_pos;
        end else begin
            sr_q <= sr_q >> 1;
        end
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/emb_lane_tx.sv
module emb_lane_tx
    import elc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int BUF_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sol,
    input  logic             in_sof,
    output logic [LANES-1:0] lane_o
);
    localparam int CNTW = $clog2(SYM_W);

    logic [CNTW-1:0]      slot_cnt_q;
    logic                 take;
    lane_sym_t [LANES-1:0] plan;

    assign take = (slot_cnt_q == CNTW'(SYM_W - 1));

    always_ff @(posedge clk) begin
        if (rst) slot_cnt_q <= CNTW'(SYM_W - 1);
        else     slot_cnt_q <= take ? '0 : slot_cnt_q + 1'b1;
    end

    elc_pack #(.LANES(LANES), .BUF_BYTES(BUF_BYTES)) pack_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_sol(in_sol), .in_sof(in_sof), .take(take),
        .in_ready(in_ready), .plan(plan)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        elc_lane lane_i (
            .clk(clk), .rst(rst), .load(take), .sym(plan[l]), .bit_o(lane_o[l])
        );
    end

endmodule

// File: rtl/elc_tx_chk.sv
module elc_tx_chk
    import elc_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  in_sol,
    input logic                  in_sof,
    input logic                  take,
    input lane_sym_t [LANES-1:0] plan,
    input logic [LANES-1:0]      lane_o
);
    logic       seen_q;
    logic [3:0] gap_q;
    logic [3:0] acc_q [LANES];
    logic [3:0] tot   [LANES];
    logic       rd_q  [LANES];
    logic       mk_any, mk_same;

    always_comb begin
        mk_any  = (plan[0].kind == SK_LINE) || (plan[0].kind == SK_FRAME);
        mk_same = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            tot[l] = acc_q[l] + {3'b000, lane_o[l]};
            if (plan[l].kind != plan[0].kind) mk_same = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
            for (int l = 0; l < LANES; l++) begin
                acc_q[l] <= '0;
                rd_q[l]  <= 1'b0;
            end
        end else begin
            if (take) seen_q <= 1'b1;
            gap_q <= take ? '0 : ((gap_q == 4'hF) ? gap_q : gap_q + 1'b1);
            for (int l = 0; l < LANES; l++) begin
                if (take) begin
                    acc_q[l] <= '0;
                    if (seen_q) rd_q[l] <= (tot[l] > 4'd5) ? 1'b1 :
                                           ((tot[l] < 4'd5) ? 1'b0 : rd_q[l]);
                end else if (seen_q) begin
                    acc_q[l] <= tot[l];
                end
            end
        end
    end

    // R9
    marker_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (in_sol || in_sof)) |=> !in_ready);

    // R7
    marker_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        mk_any |-> mk_same);

    // R2
    slot_period_chk: assert property (@(posedge clk) disable iff (rst)
        (take && seen_q) |-> (gap_q == 4'(SYM_W - 1)));

    for (genvar l = 0; l < LANES; l++) begin : g_lchk
        // R3
        disparity_chk: assert property (@(posedge clk) disable iff (rst)
            (take && seen_q) |-> ((tot[l] >= 4'd4) && (tot[l] <= 4'd6) &&
                                  !(tot[l] == 4'd6 && rd_q[l]) &&
                                  !(tot[l] == 4'd4 && !rd_q[l])));
        if (l > 0) begin : g_ord
            // R8
            lane_order_chk: assert property (@(posedge clk) disable iff (rst)
                (plan[l].kind == SK_DATA) |-> (plan[l-1].kind == SK_DATA));
        end
    end

endmodule

bind emb_lane_tx elc_tx_chk #(.LANES(LANES)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sol(in_sol), .in_sof(in_sof), .take(take), .plan(plan), .lane_o(lane_o)
);

// File: tb/emb_lane_tx_tb_top.sv
`timescale 1ns/1ps
module emb_lane_tx_tb_top;

    localparam int NL  = 4;
    localparam int TOK_SOL = 256, TOK_SOF = 257, TOK_IDLE = 258;

    logic          clk = 1'b0, rst = 1'b1;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [11:0]   in_pix = '0;
    logic          in_ready;
    logic [NL-1:0] lane;

    emb_lane_tx #(.LANES(NL), .BUF_BYTES(8)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sol(in_sol), .in_sof(in_sof), .lane_o(lane)
    );

    always #2 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    int    exp_q[$];
    bit    done = 1'b0, last_idle = 1'b0;
    string byte_tag = "R4";

    function automatic void chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    function automatic logic [5:0] t6(int x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
           15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
           18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
           21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
           27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
           30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] t4(int y);
        case (y)
            0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    // abcdeifghj written MSB-first -> transmit order (bit 0 = a)
    function automatic logic [9:0] tx_order(logic [9:0] w);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = w[9-i];
        return r;
    endfunction

    // decode one received symbol; -1 on any code or disparity violation
    function automatic int dec(logic [9:0] s, inout bit rd);
        logic [5:0] s6;
        logic [3:0] s4;
        logic [9:0] w, kw;
        int  x, y, o6, o4, ow;
        bit  r, alt, need_alt;
        w  = tx_order(s);
        s6 = w[9:4];
        s4 = w[3:0];
        ow = $countones(w);
        if (s6 == 6'b001111 || s6 == 6'b110000) begin
            for (int k = 0; k < 3; k++) begin
                kw = (k == 0) ? 10'b0011110100 : ((k == 1) ? 10'b0011110101 : 10'b0011111010);
                if (rd) kw = ~kw;
                if (w == kw) begin
                    rd = (ow > 5) ? 1'b1 : ((ow < 5) ? 1'b0 : rd);
                    return (k == 0) ? TOK_SOL : ((k == 1) ? TOK_SOF : TOK_IDLE);
                end
            end
            return -1;
        end
        r = rd;
        x = -1;
        for (int i = 0; i < 32; i++)
            if (s6 == t6(i) || (s6 == ~t6(i) && ($countones(t6(i)) != 3 || i == 7))) x = i;
        if (x < 0) return -1;
        o6 = $countones(s6);
        if ((o6 == 4 && r) || (o6 == 2 && !r)) return -1;
        if (x == 7 && s6 != (r ? 6'b000111 : 6'b111000)) return -1;
        r = (o6 > 3) ? 1'b1 : ((o6 < 3) ? 1'b0 : r);
        y = -1;
        alt = 1'b0;
        if (s4 == 4'b0111 || s4 == 4'b1000) begin
            y = 7;
            alt = 1'b1;
        end else begin
            for (int i = 0; i < 8; i++)
                if (s4 == t4(i) || (s4 == ~t4(i) && ($countones(t4(i)) != 2 || i == 3))) y = i;
        end
        if (y < 0) return -1;
        need_alt = r ? (x == 11 || x == 13 || x == 14) : (x == 17 || x == 18 || x == 20);
        if (y == 7 && alt != need_alt) return -1;
        o4 = $countones(s4);
        if ((o4 == 3 && r) || (o4 == 1 && !r)) return -1;
        if (y == 3 && s4 != (r ? 4'b0011 : 4'b1100)) return -1;
        r = (o4 > 2) ? 1'b1 : ((o4 < 2) ? 1'b0 : r);
        rd = r;
        return y * 32 + x;
    endfunction

    // lane monitor: deserialize, decode, compare with the pixel model
    initial begin
        logic [9:0] sym [NL];
        bit         rdl [NL];
        int         tk  [NL];
        int         slot = 0, nd, e;
        bit         flush_pend = 1'b0, mk, all_idle;
        for (int l = 0; l < NL; l++) rdl[l] = 1'b0;
        wait (rst == 1'b0);
        @(posedge clk);
        forever begin
            for (int b = 0; b < 10; b++) begin
                @(negedge clk);
                for (int l = 0; l < NL; l++) sym[l][b] = lane[l];
            end
            slot++;
            for (int l = 0; l < NL; l++) begin
                tk[l] = dec(sym[l], rdl[l]);
                if (tk[l] < 0) chk(1'b0, "R3", int'(sym[l]), 0);
            end
            if (slot == 1)
                for (int l = 0; l < NL; l++)
                    chk(sym[l] == tx_order(10'b0011111010), "R1 R2", int'(sym[l]),
                        int'(tx_order(10'b0011111010)));
            mk = (tk[0] == TOK_SOL || tk[0] == TOK_SOF);
            all_idle = 1'b1;
            for (int l = 0; l < NL; l++) if (tk[l] != TOK_IDLE) all_idle = 1'b0;
            last_idle = all_idle;
            if (mk) begin
                for (int l = 1; l < NL; l++) chk(tk[l] == tk[0], "R7", tk[l], tk[0]);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -9;
                chk(tk[0] == e, "R7", tk[0], e);
                flush_pend = 1'b0;
            end else if (!all_idle) begin
                chk(!flush_pend, "R8", 0, 1);
                nd = 0;
                while (nd < NL && tk[nd] >= 0 && tk[nd] < 256) nd++;
                for (int l = nd; l < NL; l++) chk(tk[l] == TOK_IDLE, "R5", tk[l], TOK_IDLE);
                if (nd < NL) flush_pend = 1'b1;
                for (int l = 0; l < nd; l++) begin
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : -9;
                    chk(tk[l] == e, byte_tag, tk[l], e);
                end
            end
        end
    end

    bit         m_half = 1'b0;
    logic [11:0] m_held = '0;

    task automatic send(logic [11:0] p, bit sol, bit sof);
        logic [23:0] w;
        @(negedge clk);
        in_valid = 1'b1; in_pix = p; in_sol = sol; in_sof = sof;
        while (!in_ready) @(negedge clk);
        if (sol || sof) begin
            exp_q.push_back(sof ? TOK_SOF : TOK_SOL);
            m_held = p; m_half = 1'b1;
        end else if (m_half) begin
            w = {p, m_held};
            exp_q.push_back(int'(w[7:0]));
            exp_q.push_back(int'(w[15:8]));
            exp_q.push_back(int'(w[23:16]));
            m_half = 1'b0;
        end else begin
            m_held = p; m_half = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        if (sol || sof) chk(!in_ready, "R9", int'(in_ready), 0);
        if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 6)) @(negedge clk);
    endtask

    initial begin
        int n;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        for (int ln = 0; ln < 14; ln++) begin
            n = 2 * $urandom_range(1, 20);
            if (ln == 5) n = 2 * $urandom_range(1, 10) + 1;   // R10 odd line
            byte_tag = (ln == 6) ? "R10" : "R4";
            for (int i = 0; i < n; i++) begin
                logic [11:0] p;
                p = 12'($urandom);
                if (ln == 3) p = (i % 2 == 0) ? 12'hFFF : 12'h000;      // R3 run-length stress
                if (ln == 4) p = (i % 2 == 0) ? 12'hEF1 : 12'h7F2;      // R3 D.x.7 alternates
                send(p, i == 0 && ln != 0, i == 0 && (ln == 0 || ln == 9));
            end
            if (ln == 7) repeat (60) @(negedge clk);                     // R6 idle gap
        end
        send(12'h123, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
        chk(last_idle, "R6", int'(last_idle), 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule